// File: doc/BRIEF.md
# Handshaked Single-Channel Block Mover

This block is one DMA channel. It copies a block of data from a source region to a destination region through a simple memory-mapped master port. Software sets the channel up through a small register port. It writes the two start addresses, a control word (item widths, address stepping, endpoint kinds and handshake choice) and the block length. It then sets the global enable and the channel enable. The channel reads source items, packs their bytes into a small byte buffer, and writes destination items of its own width. Only one bus operation is outstanding at a time.

Either endpoint may be memory or a peripheral. A memory endpoint moves freely. A peripheral endpoint moves only the items it asks for. It asks through request pins (hardware handshake) or through request bits that software writes (software handshake). A single request moves one item. A burst request moves four items, or fewer if fewer remain. When a transaction ends, the channel reports it back: as a one-cycle acknowledge pulse on a pin, or as a sticky flag that software reads. When the last item has been written, the channel sets both completion status flags and clears its own enable bit. Software may poll that bit.

Top module: `dma_hs_channel`

## Requirements
- R1: After reset every register reads 0, no master request is raised and `irq` is low.
- R2: The channel moves data only while both the channel enable (register 1, bit 0) and the global enable (register 0, bit 0) are 1. Writing 1 to the channel enable while the global enable is 0 latches the enable but causes no bus access until the global enable is set.
- R3: Register 4 holds the control word. Bits [1:0] give the source width and bits [3:2] the destination width, each coded 0 = 8 bit, 1 = 16 bit, 2 = 32 bit. The block length in register 5 counts source items. Source bytes are taken lowest byte first and packed, in order, into destination items.
- R4: Register 4 also gives the address step for each side: source in bits [5:4], destination in bits [7:6]. A value of 0 steps up by that side's item size, 1 steps down by it, and 2 keeps the address fixed. The start addresses are in register 2 (source) and register 3 (destination).
- R5: Control bit 8 marks the source as a peripheral and bit 9 marks the destination as a peripheral. A side not marked as a peripheral is memory and moves without any request.
- R6: With hardware handshake (control bit 10 for the source or bit 11 for the destination equal to 0), a peripheral side waits for a request pin. A single request moves exactly one item. A burst request moves four items, clamped to the items that remain. One acknowledge pulse follows the last item of each transaction.
- R7: With software handshake (the same bit equal to 1), writing register 6 acts as the request: bit 0 is a source single, bit 1 a source burst, bit 2 a destination single and bit 3 a destination burst. The request pins of that side are ignored. The end of a transaction sets register 7 bit 0 (source) or bit 1 (destination), and writing 1 to that bit clears it.
- R8: When the block completes, register 8 bits 0 and 1 (block done, transfer done) are set and the channel enable bit returns to 0.
- R9: `irq` is high while any status bit in register 8 is set together with its mask bit in register 9. Writing 1 to a status bit clears it.
- R10: Writes to registers 2 to 5 are ignored while the channel enable is 1.
- R11: Once raised, a master request holds its address, direction and size until `mem_ack`.
- R12: A block length of 0 completes at once with no bus access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Master access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_size | output | 2 | Access size code (0/1/2 = 1/2/4 bytes) |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 32 | Write data, right-aligned |
| mem_rdata | input | 32 | Read data, right-aligned |
| mem_ack | input | 1 | Access complete |
| src_req_single | input | 1 | Source single request |
| src_req_burst | input | 1 | Source burst request |
| src_ack | output | 1 | Source transaction acknowledge pulse |
| dst_req_single | input | 1 | Destination single request |
| dst_req_burst | input | 1 | Destination burst request |
| dst_ack | output | 1 | Destination transaction acknowledge pulse |
| irq | output | 1 | Combined masked interrupt |

## Verification
The bench builds the channel with its defaults: 32-bit addresses, a 12-bit length field and bursts of four. Each memory-to-memory run moves eight bytes. This lets the bench cover every pairing of source width, destination width, source step and destination step, 81 runs in all. In those runs packing, unpacking, stepping down and fixed addresses meet in every combination, and the bench computes the expected destination image byte by byte. Short directed runs with a six-word source peripheral and a three-byte destination peripheral cover the remaining cases: the clamped final burst, acknowledge counting, the software-request path and the ignored pins.

// File: rtl/dma_hs_pkg.sv
package dma_hs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_RD,
        ST_WR
    } eng_st_e;

    // control word, least significant member last
    typedef struct packed {
        logic       dst_sw;
        logic       src_sw;
        logic       dst_per;
        logic       src_per;
        logic [1:0] dst_mode;
        logic [1:0] src_mode;
        logic [1:0] dst_w;
        logic [1:0] src_w;
    } chan_ctrl_t;

    localparam logic [3:0] RA_GCFG  = 4'd0;
    localparam logic [3:0] RA_CHEN  = 4'd1;
    localparam logic [3:0] RA_SRC   = 4'd2;
    localparam logic [3:0] RA_DST   = 4'd3;
    localparam logic [3:0] RA_CTRL  = 4'd4;
    localparam logic [3:0] RA_BLK   = 4'd5;
    localparam logic [3:0] RA_SWREQ = 4'd6;
    localparam logic [3:0] RA_SWACK = 4'd7;
    localparam logic [3:0] RA_STAT  = 4'd8;
    localparam logic [3:0] RA_MASK  = 4'd9;

    function automatic logic [1:0] w_shift(input logic [1:0] w);
        return (w >= 2'd2) ? 2'd2 : w;
    endfunction

    function automatic logic [2:0] w_bytes(input logic [1:0] w);
        return 3'd1 << w_shift(w);
    endfunction

    function automatic logic [31:0] lane_mask(input logic [1:0] w);
        case (w_shift(w))
            2'd0:    return 32'h0000_00FF;
            2'd1:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/dma_hs_side.sv
module dma_hs_side #(
    parameter int BURST  = 4,
    parameter int LEFT_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              active,
    input  logic              periph,
    input  logic              sw_sel,
    input  logic [LEFT_W-1:0] left,
    input  logic              hw_single,
    input  logic              hw_burst,
    input  logic              sw_single,
    input  logic              sw_burst,
    input  logic              item_done,
    output logic              ok,
    output logic              hw_ack,
    output logic              sw_ack_set
);
    localparam int CW = $clog2(BURST + 1);

    typedef struct packed {
        logic [CW-1:0] credit;
        logic          ack;
    } side_t;

    side_t q, d;
    logic  want_single, want_burst;

    always_comb begin
        d           = q;
        d.ack       = 1'b0;
        want_single = sw_sel ? sw_single : hw_single;
        want_burst  = sw_sel ? sw_burst  : hw_burst;
        if (start) begin
            d.credit = '0;
        end else if (q.credit == '0) begin
            if (active && periph && left != '0) begin
                if (want_burst)
                    d.credit = (left >= LEFT_W'(BURST)) ? CW'(BURST) : CW'(left);
                else if (want_single)
                    d.credit = CW'(1);
            end
        end else if (item_done) begin
            d.credit = q.credit - CW'(1);
            if (q.credit == CW'(1))
                d.ack = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ok         = !periph || (q.credit != '0);
    assign hw_ack     = q.ack && !sw_sel;
    assign sw_ack_set = q.ack && sw_sel;

    assert_credit_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        q.credit <= CW'(BURST));
    assert_ack_follows_item_R6: assert property (@(posedge clk) disable iff (!rst_n)
        item_done && periph && q.credit == CW'(1) |=> q.ack);

endmodule

// File: rtl/dma_hs_pack.sv
module dma_hs_pack #(
    parameter int LANE_BYTES = 4
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  clear,
    input  logic                                  push,
    input  logic [$clog2(LANE_BYTES+1)-1:0]       push_n,
    input  logic [8*LANE_BYTES-1:0]               push_data,
    input  logic                                  pop,
    input  logic [$clog2(LANE_BYTES+1)-1:0]       pop_n,
    output logic [$clog2(2*LANE_BYTES+1)-1:0]     fill,
    output logic [8*LANE_BYTES-1:0]               head
);
    localparam int BUF_BYTES = 2 * LANE_BYTES;
    localparam int FW        = $clog2(BUF_BYTES + 1);
    localparam int BW        = 8 * BUF_BYTES;

    typedef struct packed {
        logic [BW-1:0] data;
        logic [FW-1:0] cnt;
    } pack_t;

    pack_t q, d;

    always_comb begin
        d = q;
        if (clear) begin
            d.data = '0;
            d.cnt  = '0;
        end else if (push) begin
            d.data = q.data | (BW'(push_data) << {q.cnt, 3'b000});
            d.cnt  = q.cnt + FW'(push_n);
        end else if (pop) begin
            d.data = q.data >> {pop_n, 3'b000};
            d.cnt  = q.cnt - FW'(pop_n);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign fill = q.cnt;
    assign head = q.data[8*LANE_BYTES-1:0];

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        push && !clear |-> (int'(q.cnt) + int'(push_n)) <= BUF_BYTES);
    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pop && !clear |-> int'(q.cnt) >= int'(pop_n));

endmodule

// File: rtl/dma_hs_channel.sv
module dma_hs_channel
    import dma_hs_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BLK_W     = 12,
    parameter int BURST_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [3:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [1:0]        mem_size,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ack,
    input  logic              src_req_single,
    input  logic              src_req_burst,
    output logic              src_ack,
    input  logic              dst_req_single,
    input  logic              dst_req_burst,
    output logic              dst_ack,
    output logic              irq
);
    localparam int LANE_BYTES = 4;
    localparam int DLEFT_W    = BLK_W + 2;
    localparam int FW         = $clog2(2 * LANE_BYTES + 1);
    localparam int NW         = $clog2(LANE_BYTES + 1);

    typedef struct packed {
        logic               gen;
        logic               chen;
        logic [ADDR_W-1:0]  src_cfg;
        logic [ADDR_W-1:0]  dst_cfg;
        chan_ctrl_t         ctrl;
        logic [BLK_W-1:0]   blk;
        logic [1:0]         swack;
        logic [1:0]         stat;
        logic [1:0]         mask;
        eng_st_e            st;
        logic [ADDR_W-1:0]  sa;
        logic [ADDR_W-1:0]  da;
        logic [BLK_W-1:0]   src_left;
        logic [DLEFT_W-1:0] dst_left;
    } chan_t;

    chan_t q, d;

    function automatic logic [ADDR_W-1:0] adv(input logic [ADDR_W-1:0] a,
                                              input logic [1:0] mode,
                                              input logic [1:0] w);
        logic [ADDR_W-1:0] s;
        s = ADDR_W'(w_bytes(w));
        case (mode)
            2'd0:    return a + s;
            2'd1:    return a - s;
            default: return a;
        endcase
    endfunction

    logic               start, active, src_done, dst_done;
    logic               can_rd, can_wr;
    logic [2:0]         sb, db;
    logic [FW-1:0]      fill;
    logic [31:0]        pk_head;
    logic [DLEFT_W-1:0] dst_items;
    logic               src_ok, dst_ok, src_sw_ack, dst_sw_ack;
    logic               swreq_wr;

    assign start     = reg_wr && reg_addr == RA_CHEN && reg_wdata[0] && !q.chen;
    assign active    = q.chen && q.gen;
    assign src_done  = (q.st == ST_RD) && mem_ack;
    assign dst_done  = (q.st == ST_WR) && mem_ack;
    assign sb        = w_bytes(q.ctrl.src_w);
    assign db        = w_bytes(q.ctrl.dst_w);
    assign swreq_wr  = reg_wr && reg_addr == RA_SWREQ;
    assign dst_items = ({2'b00, q.blk} << w_shift(q.ctrl.src_w)) >> w_shift(q.ctrl.dst_w);
    assign can_rd    = q.src_left != '0 && src_ok
                       && ((5'(fill) + 5'(sb)) <= 5'(2 * LANE_BYTES));
    assign can_wr    = q.dst_left != '0 && dst_ok && (fill >= FW'(db));

    dma_hs_side #(.BURST(BURST_LEN), .LEFT_W(BLK_W)) u_src_side (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .active     (active),
        .periph     (q.ctrl.src_per),
        .sw_sel     (q.ctrl.src_sw),
        .left       (q.src_left),
        .hw_single  (src_req_single),
        .hw_burst   (src_req_burst),
        .sw_single  (swreq_wr && reg_wdata[0]),
        .sw_burst   (swreq_wr && reg_wdata[1]),
        .item_done  (src_done),
        .ok         (src_ok),
        .hw_ack     (src_ack),
        .sw_ack_set (src_sw_ack)
    );

    dma_hs_side #(.BURST(BURST_LEN), .LEFT_W(DLEFT_W)) u_dst_side (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .active     (active),
        .periph     (q.ctrl.dst_per),
        .sw_sel     (q.ctrl.dst_sw),
        .left       (q.dst_left),
        .hw_single  (dst_req_single),
        .hw_burst   (dst_req_burst),
        .sw_single  (swreq_wr && reg_wdata[2]),
        .sw_burst   (swreq_wr && reg_wdata[3]),
        .item_done  (dst_done),
        .ok         (dst_ok),
        .hw_ack     (dst_ack),
        .sw_ack_set (dst_sw_ack)
    );

    dma_hs_pack #(.LANE_BYTES(LANE_BYTES)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (start),
        .push      (src_done),
        .push_n    (NW'(sb)),
        .push_data (mem_rdata & lane_mask(q.ctrl.src_w)),
        .pop       (dst_done),
        .pop_n     (NW'(db)),
        .fill      (fill),
        .head      (pk_head)
    );

    always_comb begin
        d = q;
        if (reg_wr) begin
            case (reg_addr)
                RA_GCFG: d.gen = reg_wdata[0];
                RA_CHEN: if (start) begin
                    d.chen     = 1'b1;
                    d.st       = ST_RUN;
                    d.sa       = q.src_cfg;
                    d.da       = q.dst_cfg;
                    d.src_left = q.blk;
                    d.dst_left = dst_items;
                end
                RA_SRC:   if (!q.chen) d.src_cfg = reg_wdata[ADDR_W-1:0];
                RA_DST:   if (!q.chen) d.dst_cfg = reg_wdata[ADDR_W-1:0];
                RA_CTRL:  if (!q.chen) d.ctrl = chan_ctrl_t'(reg_wdata[11:0]);
                RA_BLK:   if (!q.chen) d.blk = reg_wdata[BLK_W-1:0];
                RA_SWACK: d.swack = q.swack & ~reg_wdata[1:0];
                RA_STAT:  d.stat  = q.stat & ~reg_wdata[1:0];
                RA_MASK:  d.mask  = reg_wdata[1:0];
                default:  ;
            endcase
        end
        case (q.st)
            ST_RUN: if (q.gen) begin
                if (can_wr)
                    d.st = ST_WR;
                else if (can_rd)
                    d.st = ST_RD;
                else if (q.src_left == '0 && q.dst_left == '0) begin
                    d.st   = ST_IDLE;
                    d.chen = 1'b0;
                    d.stat = 2'b11;
                end
            end
            ST_RD: if (mem_ack) begin
                d.st       = ST_RUN;
                d.sa       = adv(q.sa, q.ctrl.src_mode, q.ctrl.src_w);
                d.src_left = q.src_left - BLK_W'(1);
            end
            ST_WR: if (mem_ack) begin
                d.st       = ST_RUN;
                d.da       = adv(q.da, q.ctrl.dst_mode, q.ctrl.dst_w);
                d.dst_left = q.dst_left - DLEFT_W'(1);
            end
            default: ;
        endcase
        if (src_sw_ack) d.swack[0] = 1'b1;
        if (dst_sw_ack) d.swack[1] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_GCFG:  reg_rdata[0]          = q.gen;
            RA_CHEN:  reg_rdata[0]          = q.chen;
            RA_SRC:   reg_rdata[ADDR_W-1:0] = q.src_cfg;
            RA_DST:   reg_rdata[ADDR_W-1:0] = q.dst_cfg;
            RA_CTRL:  reg_rdata[11:0]       = q.ctrl;
            RA_BLK:   reg_rdata[BLK_W-1:0]  = q.blk;
            RA_SWACK: reg_rdata[1:0]        = q.swack;
            RA_STAT:  reg_rdata[1:0]        = q.stat;
            RA_MASK:  reg_rdata[1:0]        = q.mask;
            default:  reg_rdata             = '0;
        endcase
    end

    assign mem_req   = (q.st == ST_RD) || (q.st == ST_WR);
    assign mem_we    = (q.st == ST_WR);
    assign mem_addr  = mem_we ? q.da : q.sa;
    assign mem_size  = w_shift(mem_we ? q.ctrl.dst_w : q.ctrl.src_w);
    assign mem_wdata = pk_head & lane_mask(q.ctrl.dst_w);
    assign irq       = |(q.stat & q.mask);

    assert_hold_request_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_size));
    assert_gate_global_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> $past(q.gen) && $past(q.chen));
    assert_done_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.chen) |-> q.stat == 2'b11);
    assert_cfg_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_addr == RA_SRC && q.chen |=> $stable(q.src_cfg));
    assert_no_bus_when_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !q.chen |-> !mem_req);

endmodule

// File: tb/dma_hs_channel_test.sv
module dma_hs_channel_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [1:0]  mem_size;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = 32'd0;
    logic        mem_ack = 1'b0;
    logic        src_req_single = 1'b0, src_req_burst = 1'b0;
    logic        dst_req_single = 1'b0, dst_req_burst = 1'b0;
    logic        src_ack, dst_ack, irq;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    dma_hs_channel uut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .src_req_single(src_req_single), .src_req_burst(src_req_burst), .src_ack(src_ack),
        .dst_req_single(dst_req_single), .dst_req_burst(dst_req_burst), .dst_ack(dst_ack),
        .irq(irq)
    );

    // memory model: one-cycle latency, little-endian bytes, right-aligned data
    logic [7:0] mem [0:1023];
    logic [7:0] img [0:1023];
    logic [7:0] expm [0:1023];
    logic       do_init = 1'b0;
    int         seed = 0;
    int         rd_cnt = 0, wr_cnt = 0, sack_cnt = 0, dack_cnt = 0;

    always @(posedge clk) begin
        if (do_init) begin
            for (int i = 0; i < 1024; i++) mem[i] = 8'((i * 13 + seed) & 255);
        end else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                for (int b = 0; b < (1 << mem_size); b++)
                    mem[(int'(mem_addr) + b) & 1023] = mem_wdata[8*b +: 8];
                wr_cnt++;
            end else begin
                mem_rdata <= {mem[(int'(mem_addr) + 3) & 1023], mem[(int'(mem_addr) + 2) & 1023],
                              mem[(int'(mem_addr) + 1) & 1023], mem[int'(mem_addr) & 1023]};
                rd_cnt++;
            end
        end else begin
            mem_ack <= 1'b0;
        end
        if (src_ack) sack_cnt++;
        if (dst_ack) dack_cnt++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic init_mem(input int s);
        @(negedge clk);
        seed = s; do_init = 1'b1;
        @(negedge clk);
        do_init = 1'b0;
        for (int i = 0; i < 1024; i++) img[i] = mem[i];
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 600; i++) begin
            rd(4'd1, v);
            if (v[0] == 1'b0) break;
        end
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: src_req_single = 1'b1;
            1: src_req_burst  = 1'b1;
            2: dst_req_single = 1'b1;
            default: dst_req_burst = 1'b1;
        endcase
        @(negedge clk);
        src_req_single = 1'b0; src_req_burst = 1'b0;
        dst_req_single = 1'b0; dst_req_burst = 1'b0;
    endtask

    function automatic int step(input int base, input int mode, input int k, input int nb);
        if (mode == 0) return base + k * nb;
        if (mode == 1) return base - k * nb;
        return base;
    endfunction

    function automatic int mismatches();
        int m = 0;
        for (int i = 0; i < 1024; i++) if (mem[i] !== expm[i]) m++;
        return m;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  stream [0:7];
        int r0, w0, s0, d0, cfg;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 10; a++) begin
            rd(4'(a), v);
            chk($sformatf("R1 reg%0d", a), v, 32'd0);
        end
        chk("R1 mem_req", {31'd0, mem_req}, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);

        // R2: channel enable without global enable does nothing
        init_mem(99);
        wr(4'd2, 32'h100); wr(4'd3, 32'h200); wr(4'd4, 32'h0A); wr(4'd5, 32'd2);
        r0 = rd_cnt;
        wr(4'd1, 32'd1);
        repeat (20) @(negedge clk);
        chk("R2 no access without global", 32'(rd_cnt - r0), 32'd0);
        rd(4'd1, v);
        chk("R2 enable latched", v, 32'd1);
        wr(4'd0, 32'd1);
        wait_idle();
        chk("R2 runs after global", 32'(rd_cnt - r0), 32'd2);
        wr(4'd8, 32'd3);

        // R3 R4 R5 R8: memory-to-memory sweep over widths and address modes
        cfg = 0;
        for (int sw = 0; sw < 3; sw++)
        for (int dw = 0; dw < 3; dw++)
        for (int sm = 0; sm < 3; sm++)
        for (int dm = 0; dm < 3; dm++) begin
            int sbn, n, dbn, nd, a;
            cfg++;
            init_mem(cfg * 5 + 1);
            sbn = 1 << sw; n = 8 / sbn; dbn = 1 << dw; nd = 8 / dbn;
            for (int k = 0; k < n; k++) begin
                a = step(32'h140, sm, k, sbn);
                for (int b = 0; b < sbn; b++) stream[k * sbn + b] = img[(a + b) & 1023];
            end
            for (int i = 0; i < 1024; i++) expm[i] = img[i];
            for (int j = 0; j < nd; j++) begin
                a = step(32'h240, dm, j, dbn);
                for (int b = 0; b < dbn; b++) expm[(a + b) & 1023] = stream[j * dbn + b];
            end
            wr(4'd2, 32'h140); wr(4'd3, 32'h240);
            wr(4'd4, 32'(sw | (dw << 2) | (sm << 4) | (dm << 6)));
            wr(4'd5, 32'(n));
            wr(4'd1, 32'd1);
            wait_idle();
            rd(4'd8, v);
            chk($sformatf("R8 status sw%0d dw%0d sm%0d dm%0d", sw, dw, sm, dm), v, 32'd3);
            chk($sformatf("R3 R4 R5 image sw%0d dw%0d sm%0d dm%0d", sw, dw, sm, dm),
                32'(mismatches()), 32'd0);
            wr(4'd8, 32'd3);
        end

        // R6 R10: hardware-handshaked source peripheral, six words
        init_mem(7);
        for (int i = 0; i < 1024; i++) expm[i] = img[i];
        for (int i = 0; i < 24; i++) expm[32'h200 + i] = img[32'h100 + i];
        wr(4'd2, 32'h100); wr(4'd3, 32'h200); wr(4'd4, 32'h10A); wr(4'd5, 32'd6);
        r0 = rd_cnt; s0 = sack_cnt;
        wr(4'd1, 32'd1);
        repeat (10) @(negedge clk);
        chk("R6 waits for request", 32'(rd_cnt - r0), 32'd0);
        wr(4'd2, 32'hDEAD);
        rd(4'd2, v);
        chk("R10 source address locked", v, 32'h100);
        pulse(1);
        repeat (30) @(negedge clk);
        chk("R6 burst moves four", 32'(rd_cnt - r0), 32'd4);
        chk("R6 one ack per burst", 32'(sack_cnt - s0), 32'd1);
        pulse(0);
        repeat (20) @(negedge clk);
        chk("R6 single moves one", 32'(rd_cnt - r0), 32'd5);
        chk("R6 ack after single", 32'(sack_cnt - s0), 32'd2);
        pulse(1);
        repeat (20) @(negedge clk);
        chk("R6 burst clamped", 32'(rd_cnt - r0), 32'd6);
        chk("R6 ack after clamped burst", 32'(sack_cnt - s0), 32'd3);
        rd(4'd1, v);
        chk("R8 enable cleared", v, 32'd0);
        chk("R6 data", 32'(mismatches()), 32'd0);
        wr(4'd8, 32'd3);

        // R7: software-handshaked destination peripheral, three bytes
        init_mem(31);
        for (int i = 0; i < 1024; i++) expm[i] = img[i];
        for (int i = 0; i < 3; i++) expm[32'h300 + i] = img[32'h180 + i];
        wr(4'd2, 32'h180); wr(4'd3, 32'h300); wr(4'd4, 32'hA00); wr(4'd5, 32'd3);
        w0 = wr_cnt; d0 = dack_cnt;
        wr(4'd1, 32'd1);
        pulse(3);
        repeat (15) @(negedge clk);
        chk("R7 pins ignored", 32'(wr_cnt - w0), 32'd0);
        wr(4'd6, 32'h4);
        repeat (10) @(negedge clk);
        chk("R7 soft single", 32'(wr_cnt - w0), 32'd1);
        rd(4'd7, v);
        chk("R7 ack flag set", v, 32'h2);
        wr(4'd7, 32'h2);
        rd(4'd7, v);
        chk("R7 ack flag cleared", v, 32'h0);
        wr(4'd6, 32'h8);
        wait_idle();
        chk("R7 soft burst rest", 32'(wr_cnt - w0), 32'd3);
        rd(4'd7, v);
        chk("R7 ack flag after burst", v, 32'h2);
        chk("R7 no ack pin", 32'(dack_cnt - d0), 32'd0);
        chk("R7 data", 32'(mismatches()), 32'd0);
        wr(4'd7, 32'h3);

        // R9: interrupt masking with both status bits set
        wr(4'd9, 32'd0);
        @(negedge clk);
        chk("R9 masked", {31'd0, irq}, 32'd0);
        wr(4'd9, 32'd2);
        @(negedge clk);
        chk("R9 transfer bit unmasked", {31'd0, irq}, 32'd1);
        wr(4'd8, 32'd2);
        @(negedge clk);
        chk("R9 cleared bit drops irq", {31'd0, irq}, 32'd0);
        wr(4'd9, 32'd1);
        @(negedge clk);
        chk("R9 block bit unmasked", {31'd0, irq}, 32'd1);
        wr(4'd8, 32'd1);
        rd(4'd8, v);
        chk("R9 status cleared", v, 32'd0);
        chk("R9 irq low", {31'd0, irq}, 32'd0);

        // R12: zero length
        wr(4'd4, 32'h0A); wr(4'd5, 32'd0);
        r0 = rd_cnt; w0 = wr_cnt;
        wr(4'd1, 32'd1);
        repeat (5) @(negedge clk);
        rd(4'd1, v);
        chk("R12 enable cleared", v, 32'd0);
        rd(4'd8, v);
        chk("R12 status", v, 32'd3);
        chk("R12 no access", 32'((rd_cnt - r0) + (wr_cnt - w0)), 32'd0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule